// File: doc/BRIEF.md
# Flash Status Register Controller

This block keeps the 16-bit status word of a serial NOR flash command engine and decides, one cycle at a time, which decoded instruction is taken. Instruction strobes arrive already decoded from the serial front end. They cover latch control (write enable, write disable), status access (status read, status write), erase suspend, and the four array operations (page program, sector erase, block erase, whole-array erase). The block answers in the same cycle with `cmd_accept`. It updates the status word on the next clock edge.

A busy flag is raised when an array operation or a status write starts. It drops one cycle after the array timing unit pulses `op_done`. A write-enable latch must be set before any operation that modifies storage, and every such attempt clears it again. A protection level and a direction bit mark a power-of-two region of the array as read-only. Two lock bits, together with an external active-low protect pin, decide whether the status word may be rewritten. The non-volatile bits are held in ordinary registers that clear at reset. The caller drives at most one instruction strobe in any cycle.

Top module: `flash_status_ctrl`

## Requirements
- R1: After reset, `status` is 16'h0000, `busy` is 0 and no address is protected.
- R2: A write-enable strobe while idle is accepted and sets the latch at bit 1 of `status`. A write-disable strobe while idle is accepted and clears it.
- R3: A status write, program or erase issued while the latch is 0 is not accepted and leaves `status` unchanged.
- R4: An accepted program, erase or status write sets `busy` (bit 0 of `status`) and clears the latch on the next edge. `busy` returns to 0 on the edge after an `op_done` pulse seen while busy.
- R5: While busy, only status read and erase suspend are accepted, and every other strobe leaves `status` unchanged. Erase suspend is not accepted while idle. Status read is always accepted.
- R6: An accepted status write loads `wr_data` bits 4:2 into the protection level, bit 5 into the low-end select, bit 7 into the pin lock, bit 8 into the hard lock and bit 9 into the quad enable, all at the same positions in `status`. Bits 0, 1, 6 and 15:10 of `wr_data` have no effect, and bits 6 and 15:10 of `status` read 0.
- R7: A status write with the latch set is refused when the hard lock (bit 8) is 1, or when the pin lock (bit 7) is 1 and `prot_pin_n` is low. A refused write clears the latch, leaves the other bits unchanged and does not set `busy`.
- R8: Protection level n from 1 to 6 protects the 2^(n-1)/64 fraction of the array: at the top end when bit 5 is 0, and at the bottom end when bit 5 is 1. Level 0 protects nothing and level 7 protects everything.
- R9: A program, sector erase or block erase whose `op_addr` is protected, or a whole-array erase while the level is non-zero, is not accepted and does not set `busy`, but the latch is still cleared.
- R10: `addr_protected` follows `op_addr` and the current protection bits combinationally, in the same cycle.
- R11: An `op_done` pulse while idle has no effect on `status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr_en | input | 1 | Write-enable instruction strobe |
| cmd_wr_dis | input | 1 | Write-disable instruction strobe |
| cmd_st_wr | input | 1 | Status write instruction strobe |
| cmd_st_rd | input | 1 | Status read instruction strobe |
| cmd_susp | input | 1 | Erase suspend instruction strobe |
| cmd_prog | input | 1 | Page program instruction strobe |
| cmd_erase_sec | input | 1 | Sector erase instruction strobe |
| cmd_erase_blk | input | 1 | Block erase instruction strobe |
| cmd_erase_all | input | 1 | Whole-array erase instruction strobe |
| wr_data | input | 16 | Status write data, bit i targets status bit i |
| op_addr | input | ADDR_W | Target byte address of program or erase |
| prot_pin_n | input | 1 | External write-protect pin, active low |
| op_done | input | 1 | Completion pulse from the array timing unit |
| status | output | 16 | Status word |
| busy | output | 1 | Operation in progress |
| cmd_accept | output | 1 | Current strobe is taken |
| addr_protected | output | 1 | `op_addr` lies in the protected region |

## Verification
The collision of interest is a completion pulse and a new instruction in the same cycle. The bench drives `op_done` together with a page program strobe while busy. The program must be refused, because the busy gate uses the flag as it stands in that cycle, and `busy` must fall on the next edge with the latch untouched. A cycle-level reference model in the bench predicts `status`, `busy`, `cmd_accept` and `addr_protected` for every cycle, and each mismatch is reported against the requirement under test.

// File: rtl/flash_status_pkg.sv
`timescale 1ns/1ps
package flash_status_pkg;
   // status word bit positions (fixed: the serial read path shifts them out)
   localparam int ST_W      = 16;
   localparam int B_BUSY    = 0;
   localparam int B_LATCH   = 1;
   localparam int B_LVL_LO  = 2;
   localparam int LVL_W     = 3;
   localparam int B_LOWEND  = 5;
   localparam int B_PINLOCK = 7;
   localparam int B_HARDLK  = 8;
   localparam int B_QUAD    = 9;
   localparam int FRAC_LOG  = 6;   // smallest region is 1/2^FRAC_LOG

   typedef struct packed {
      logic             quad_en;
      logic             lock_hard;
      logic             lock_pin;
      logic             prot_low;
      logic [LVL_W-1:0] prot_lvl;
   } nv_bits_t;
endpackage

// File: rtl/fsr_prot_map.sv
`timescale 1ns/1ps
module fsr_prot_map
   import flash_status_pkg::*;
#(
   parameter int ADDR_W = 24
)(
   input  logic [LVL_W-1:0]  prot_lvl,
   input  logic              prot_low,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam int LVL_MAX = (1 << LVL_W) - 1;
   localparam int SH_BASE = ADDR_W - FRAC_LOG - 1;

   if (ADDR_W <= FRAC_LOG) begin : g_bad_width
      $error("fsr_prot_map: ADDR_W must exceed FRAC_LOG");
   end

   logic [ADDR_W-1:0] upper;
   logic [ADDR_W-1:0] all_ones;
   int                sh;

   always_comb begin
      sh       = SH_BASE + int'(prot_lvl);
      upper    = addr >> sh;
      all_ones = {ADDR_W{1'b1}} >> sh;
      if (prot_lvl == '0)
         hit = 1'b0;
      else if (int'(prot_lvl) == LVL_MAX)
         hit = 1'b1;
      else if (prot_low)
         hit = (upper == '0);
      else
         hit = (upper == all_ones);
   end
endmodule

// File: rtl/fsr_wr_gate.sv
`timescale 1ns/1ps
module fsr_wr_gate #(
   parameter bit PIN_GATE = 1'b1
)(
   input  logic lock_hard,
   input  logic lock_pin,
   input  logic prot_pin_n,
   output logic allow
);
   if (PIN_GATE) begin : g_pin
      assign allow = !lock_hard && (!lock_pin || prot_pin_n);
   end else begin : g_nopin
      logic unused_pin;
      assign unused_pin = lock_pin ^ prot_pin_n;
      assign allow      = !lock_hard;
   end
endmodule

// File: rtl/flash_status_ctrl.sv
`timescale 1ns/1ps
module flash_status_ctrl
   import flash_status_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter bit HAS_QUAD = 1'b1,
   parameter bit PIN_GATE = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr_en,
   input  logic              cmd_wr_dis,
   input  logic              cmd_st_wr,
   input  logic              cmd_st_rd,
   input  logic              cmd_susp,
   input  logic              cmd_prog,
   input  logic              cmd_erase_sec,
   input  logic              cmd_erase_blk,
   input  logic              cmd_erase_all,
   input  logic [15:0]       wr_data,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic              prot_pin_n,
   input  logic              op_done,
   output logic [15:0]       status,
   output logic              busy,
   output logic              cmd_accept,
   output logic              addr_protected
);
   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
      $error("flash_status_ctrl: ADDR_W out of range");
   end

   logic     busy_q, busy_d;
   logic     latch_q, latch_d;
   nv_bits_t nv_q, nv_d, nv_wr;
   logic     is_array, needs_latch;
   logic     prot_hit, array_blocked, st_allow;
   logic     quad_wr;

   assign is_array    = cmd_prog | cmd_erase_sec | cmd_erase_blk | cmd_erase_all;
   assign needs_latch = is_array | cmd_st_wr;

   fsr_prot_map #(.ADDR_W(ADDR_W)) u_map (
      .prot_lvl (nv_q.prot_lvl),
      .prot_low (nv_q.prot_low),
      .addr     (op_addr),
      .hit      (prot_hit)
   );

   fsr_wr_gate #(.PIN_GATE(PIN_GATE)) u_gate (
      .lock_hard  (nv_q.lock_hard),
      .lock_pin   (nv_q.lock_pin),
      .prot_pin_n (prot_pin_n),
      .allow      (st_allow)
   );

   // whole-array erase is refused whenever any region is protected
   assign array_blocked = cmd_erase_all ? (nv_q.prot_lvl != '0) : prot_hit;

   if (HAS_QUAD) begin : g_quad
      assign quad_wr = wr_data[B_QUAD];
   end else begin : g_noquad
      logic unused_quad;
      assign unused_quad = wr_data[B_QUAD];
      assign quad_wr     = 1'b0;
   end

   logic unused_wr;
   assign unused_wr = ^{wr_data[15:10], wr_data[6], wr_data[1:0]};

   assign nv_wr = '{quad_en:   quad_wr,
                    lock_hard: wr_data[B_HARDLK],
                    lock_pin:  wr_data[B_PINLOCK],
                    prot_low:  wr_data[B_LOWEND],
                    prot_lvl:  wr_data[B_LVL_LO +: LVL_W]};

   always_comb begin
      busy_d     = busy_q;
      latch_d    = latch_q;
      nv_d       = nv_q;
      cmd_accept = 1'b0;
      if (busy_q) begin
         cmd_accept = cmd_st_rd | cmd_susp;
         if (op_done) busy_d = 1'b0;
      end else begin
         if (cmd_st_rd) cmd_accept = 1'b1;
         if (cmd_wr_en) begin
            cmd_accept = 1'b1;
            latch_d    = 1'b1;
         end
         if (cmd_wr_dis) begin
            cmd_accept = 1'b1;
            latch_d    = 1'b0;
         end
         if (needs_latch && latch_q) begin
            latch_d = 1'b0;
            if (cmd_st_wr && st_allow) begin
               cmd_accept = 1'b1;
               busy_d     = 1'b1;
               nv_d       = nv_wr;
            end
            if (is_array && !array_blocked) begin
               cmd_accept = 1'b1;
               busy_d     = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         latch_q <= 1'b0;
         nv_q    <= '0;
      end else begin
         busy_q  <= busy_d;
         latch_q <= latch_d;
         nv_q    <= nv_d;
      end
   end

   always_comb begin
      status                            = '0;
      status[B_BUSY]                    = busy_q;
      status[B_LATCH]                   = latch_q;
      status[B_LVL_LO +: LVL_W]         = nv_q.prot_lvl;
      status[B_LOWEND]                  = nv_q.prot_low;
      status[B_PINLOCK]                 = nv_q.lock_pin;
      status[B_HARDLK]                  = nv_q.lock_hard;
      status[B_QUAD]                    = nv_q.quad_en;
   end

   assign busy           = busy_q;
   assign addr_protected = prot_hit;

   // R4: busy only rises after an accepted instruction
   a_r4_busy_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(cmd_accept));
   // R4: completion while busy releases the flag
   a_r4_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && op_done |=> !busy_q);
   // R4: every accepted modifying instruction drops the latch
   a_r4_latch_drops: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_accept && needs_latch |=> !latch_q);
   // R5: only status read and suspend pass while busy
   a_r5_busy_gate: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !cmd_st_rd && !cmd_susp |-> !cmd_accept);
   // R2: write enable while idle sets the latch
   a_r2_latch_set: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q && cmd_wr_en |=> latch_q);
   // R7: hard lock freezes the non-volatile bits
   a_r7_hard_lock: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q && cmd_st_wr && nv_q.lock_hard |=> $stable(nv_q));
   // R9: a protected target never starts an operation
   a_r9_prot_reject: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q && is_array && array_blocked |=> !busy_q);
   // R8: the extreme ends are protected at the top level
   a_r8_full_level: assert property (@(posedge clk) disable iff (!rst_n)
      nv_q.prot_lvl == 3'd7 |-> addr_protected);
endmodule

// File: tb/flash_status_ctrl_bench.sv
`timescale 1ns/1ps
module flash_status_ctrl_bench;
   localparam int AW = 24;
   localparam int C_NONE = 0, C_WREN = 1, C_WRDI = 2, C_STWR = 3, C_STRD = 4,
                  C_SUSP = 5, C_PROG = 6, C_SEC = 7, C_BLK = 8, C_ALL = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_wr_en = 0, cmd_wr_dis = 0, cmd_st_wr = 0, cmd_st_rd = 0;
   logic          cmd_susp = 0, cmd_prog = 0, cmd_erase_sec = 0, cmd_erase_blk = 0;
   logic          cmd_erase_all = 0;
   logic [15:0]   wr_data = '0;
   logic [AW-1:0] op_addr = '0;
   logic          prot_pin_n = 1'b1;
   logic          op_done = 1'b0;
   logic [15:0]   status;
   logic          busy, cmd_accept, addr_protected;

   int n_chk = 0, n_fail = 0;

   // reference state
   bit m_busy, m_latch, m_low, m_pin, m_hard, m_quad;
   int m_lvl;

   always #2 clk = ~clk;

   flash_status_ctrl #(.ADDR_W(AW)) u_flash_status_ctrl (
      .clk, .rst_n, .cmd_wr_en, .cmd_wr_dis, .cmd_st_wr, .cmd_st_rd, .cmd_susp,
      .cmd_prog, .cmd_erase_sec, .cmd_erase_blk, .cmd_erase_all, .wr_data,
      .op_addr, .prot_pin_n, .op_done, .status, .busy, .cmd_accept, .addr_protected);

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic bit m_prot(int addr);
      int size, region;
      size = 1 << AW;
      if (m_lvl == 0) return 1'b0;
      if (m_lvl == 7) return 1'b1;
      region = size >> (7 - m_lvl);
      return m_low ? (addr < region) : (addr >= size - region);
   endfunction

   function automatic int m_status();
      return m_busy + 2*m_latch + 4*m_lvl + 32*m_low + 128*m_pin + 256*m_hard + 512*m_quad;
   endfunction

   task automatic step(string tag, int cmd, int data, int addr, bit pin, bit done);
      bit exp_acc, exp_prot, gate_ok, arr, blocked;
      cmd_wr_en = (cmd == C_WREN);  cmd_wr_dis = (cmd == C_WRDI);
      cmd_st_wr = (cmd == C_STWR);  cmd_st_rd = (cmd == C_STRD);
      cmd_susp = (cmd == C_SUSP);   cmd_prog = (cmd == C_PROG);
      cmd_erase_sec = (cmd == C_SEC); cmd_erase_blk = (cmd == C_BLK);
      cmd_erase_all = (cmd == C_ALL);
      wr_data = data[15:0]; op_addr = addr[AW-1:0]; prot_pin_n = pin; op_done = done;
      #1;
      exp_prot = m_prot(addr);
      arr      = (cmd >= C_PROG);
      blocked  = (cmd == C_ALL) ? (m_lvl != 0) : exp_prot;
      gate_ok  = !m_hard && (!m_pin || pin);
      if (m_busy) exp_acc = (cmd == C_STRD) || (cmd == C_SUSP);
      else exp_acc = (cmd == C_STRD) || (cmd == C_WREN) || (cmd == C_WRDI) ||
                     (m_latch && cmd == C_STWR && gate_ok) || (m_latch && arr && !blocked);
      chk(tag, "status", int'(status), m_status());
      chk(tag, "busy", int'(busy), int'(m_busy));
      chk(tag, "accept", int'(cmd_accept), int'(exp_acc));
      chk(tag, "protected", int'(addr_protected), int'(exp_prot));
      if (m_busy) begin
         if (done) m_busy = 0;
      end else begin
         if (cmd == C_WREN) m_latch = 1;
         else if (cmd == C_WRDI) m_latch = 0;
         else if ((cmd == C_STWR || arr) && m_latch) begin
            m_latch = 0;
            if (exp_acc) m_busy = 1;
            if (exp_acc && cmd == C_STWR) begin
               m_lvl  = (data >> 2) & 7;
               m_low  = data[5];
               m_pin  = data[7];
               m_hard = data[8];
               m_quad = data[9];
            end
         end
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle(string tag, int n);
      for (int i = 0; i < n; i++) step(tag, C_NONE, 0, 0, 1, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      step("R1", C_NONE, 0, 'hFFFFFF, 1, 0);
      step("R1", C_STRD, 0, 0, 1, 0);
      // R11 completion while idle
      step("R11", C_NONE, 0, 0, 1, 1);
      // R3 modifying instructions with the latch clear
      step("R3", C_PROG, 0, 'h100, 1, 0);
      step("R3", C_STWR, 'h03FC, 0, 1, 0);
      step("R3", C_ALL, 0, 0, 1, 0);
      // R2 latch control
      step("R2", C_WREN, 0, 0, 1, 0);
      step("R2", C_WRDI, 0, 0, 1, 0);
      step("R5", C_SUSP, 0, 0, 1, 0);
      step("R2", C_WREN, 0, 0, 1, 0);
      // R6 field mapping, reserved bits set in data
      step("R6", C_STWR, 'hFE7F, 0, 1, 0);
      // R5 gating while busy
      step("R5", C_WREN, 0, 0, 1, 0);
      step("R5", C_STRD, 0, 0, 1, 0);
      step("R5", C_SUSP, 0, 0, 1, 0);
      step("R5", C_STWR, 0, 0, 1, 0);
      // completion coinciding with a program strobe
      step("R4", C_PROG, 0, 0, 1, 1);
      step("R4", C_NONE, 0, 0, 1, 0);
      // R9 everything protected at level 7
      step("R10", C_NONE, 0, 'h123456, 1, 0);
      step("R9", C_WREN, 0, 0, 1, 0);
      step("R9", C_SEC, 0, 'h400000, 1, 0);
      step("R9", C_NONE, 0, 0, 1, 0);
      // level 1, top end
      step("R6", C_WREN, 0, 0, 1, 0);
      step("R6", C_STWR, 'h0004, 0, 1, 0);
      step("R4", C_NONE, 0, 0, 1, 1);
      step("R8", C_NONE, 0, 'hFC0000, 1, 0);
      step("R8", C_NONE, 0, 'hFBFFFF, 1, 0);
      step("R8", C_NONE, 0, 'hFFFFFF, 1, 0);
      step("R4", C_WREN, 0, 0, 1, 0);
      step("R4", C_PROG, 0, 'hFBFFFF, 1, 0);
      idle("R4", 2);
      step("R4", C_NONE, 0, 0, 1, 1);
      step("R9", C_WREN, 0, 0, 1, 0);
      step("R9", C_ALL, 0, 'h000000, 1, 0);
      step("R9", C_WREN, 0, 0, 1, 0);
      step("R9", C_BLK, 0, 'hFC8000, 1, 0);
      // level 3, bottom end
      step("R8", C_WREN, 0, 0, 1, 0);
      step("R8", C_STWR, 'h002C, 0, 1, 0);
      step("R8", C_NONE, 0, 0, 1, 1);
      step("R8", C_NONE, 0, 'h03FFFF, 1, 0);
      step("R10", C_NONE, 0, 'h040000, 1, 0);
      step("R8", C_NONE, 0, 'hFFFFFF, 1, 0);
      // level 6, top end
      step("R8", C_WREN, 0, 0, 1, 0);
      step("R8", C_STWR, 'h0018, 0, 1, 0);
      step("R8", C_NONE, 0, 0, 1, 1);
      step("R8", C_NONE, 0, 'h800000, 1, 0);
      step("R8", C_NONE, 0, 'h7FFFFF, 1, 0);
      // clear level, whole-array erase allowed
      step("R6", C_WREN, 0, 0, 1, 0);
      step("R6", C_STWR, 'h0080, 0, 1, 0);
      step("R6", C_NONE, 0, 0, 1, 1);
      step("R4", C_WREN, 0, 0, 1, 0);
      step("R4", C_ALL, 0, 0, 1, 0);
      step("R4", C_NONE, 0, 0, 1, 1);
      // R7 pin lock
      step("R7", C_WREN, 0, 0, 0, 0);
      step("R7", C_STWR, 'h001C, 0, 0, 0);
      step("R7", C_NONE, 0, 0, 0, 0);
      step("R7", C_WREN, 0, 0, 1, 0);
      step("R7", C_STWR, 'h0100, 0, 1, 0);
      step("R7", C_NONE, 0, 0, 1, 1);
      // R7 hard lock
      step("R7", C_WREN, 0, 0, 1, 0);
      step("R7", C_STWR, 'h0000, 0, 1, 0);
      step("R7", C_NONE, 0, 0, 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule